// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port

This block is a full-duplex serial peripheral interface port that hangs off a simple processor register bus. Software reaches three byte registers (control, status and data) through a page enable, an address, a write strobe and write data. Reads are combinational.

In master role, a write to the data register starts an eight-bit exchange. The block drives the serial clock at a fixed fraction of the bus clock, shifts the written byte out most significant bit first and shifts the reply in at the same time. In slave role, it follows a serial clock from outside while its active-low select input is low, sending a byte preloaded through the data register.

When the exchange ends, a completion flag is raised and, if enabled, an interrupt request. A master whose select input is pulled low by another device reports a mode fault and withdraws from the bus.

Top module: `spi_port`

## Requirements
- R1: After reset, every register reads 0x00, `sck_o` is low, `ss_o` is high, and `irq_o`, `mode_fault_o`, `mosi_o` and `miso_o` are low.
- R2: The registers are at BASE (control), BASE+1 (status) and BASE+2 (data). Control bit 7 is the interrupt enable, bit 6 the port enable, bit 4 master (1) or slave (0), bit 3 the clock polarity and bit 2 the clock phase. Other control bits read 0. Status bit 7 is the completion flag and bit 4 is the mode-fault flag. The data register reads back the last received byte.
- R3: In master role with enable set, a data-register write starts an exchange of 16 clock edges, each DIV/2 bus cycles apart. The first edge comes DIV/2 cycles after the write edge. The completion flag is set at the 16th edge, 8*DIV cycles after the write edge.
- R4: Bits travel most significant first in both directions. The received byte is readable at the data register once the exchange has completed.
- R5: With phase 0, the first bit is valid before the first edge, and the lines are sampled on edges 1, 3, 5 and so on. With phase 1, the lines change on edges 1, 3, 5 and so on, and are sampled on edges 2, 4, 6 and so on.
- R6: While no exchange is in progress, `sck_o` rests at the polarity bit.
- R7: In slave role, the port sends its preloaded byte on `miso_o` and receives from `mosi_i`, only while `ss_ni` is low. It sets its completion flag at the 16th edge of `sck_i`.
- R8: `irq_o` is high exactly when the completion flag and the interrupt enable are both set.
- R9: A status write clears each flag (bits 7 and 4) whose written bit is 0.
- R10: With the enable bit clear, a data-register write causes no clock edges and no completion flag.
- R11: A master with `ss_dir_i` low whose synchronised `ss_ni` is low sets the mode-fault flag and `mode_fault_o`. It also clears the enable and master bits and aborts the exchange, leaving the clock idle.
- R12: With `ss_dir_i` high, a master drives `ss_o` low for the duration of its exchange; otherwise `ss_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Register page enable |
| bus_we_i | input | 1 | Write strobe (1 = write) |
| bus_addr_i | input | AW | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the addressed register |
| ss_ni | input | 1 | Select input, active low |
| ss_dir_i | input | 1 | 1: select pin is an output, 0: an input |
| ss_o | output | 1 | Select output, active low |
| sck_i | input | 1 | Serial clock in (slave role) |
| sck_o | output | 1 | Serial clock out (master role) |
| mosi_i | input | 1 | Serial data in (slave role) |
| mosi_o | output | 1 | Serial data out (master role) |
| miso_i | input | 1 | Serial data in (master role) |
| miso_o | output | 1 | Serial data out (slave role) |
| irq_o | output | 1 | Completion interrupt request |
| mode_fault_o | output | 1 | Mode-fault flag |

## Verification
A master exchange takes 8*DIV bus cycles from the write edge, which is 64 with the default divider. The bench therefore samples `irq_o` low one cycle before that point and high at that point, both at the falling clock edge. The slave side sees each clock edge three bus cycles late because of its synchroniser, so its flag and received byte are read some cycles after the master's. Serial bits are compared per clock edge by a monitor that samples on the sampling edges of the current phase. Mode fault is checked a fixed four cycles after the select input drops, which covers two synchroniser stages and the flag register.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int unsigned REG_W = 8;
  // control bit positions
  localparam int unsigned CB_IEN = 7;
  localparam int unsigned CB_EN  = 6;
  localparam int unsigned CB_MST = 4;
  localparam int unsigned CB_POL = 3;
  localparam int unsigned CB_PHA = 2;
  // status bit positions
  localparam int unsigned SB_DONE  = 7;
  localparam int unsigned SB_FAULT = 4;

  typedef struct packed {
    logic ien;
    logic en;
    logic mst;
    logic pol;
    logic pha;
  } ctrl_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned STAGES  = 3,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              d_i,
  output logic [STAGES-1:0] q_o
);
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q_o[0] <= RST_VAL;
        else         q_o[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q_o[i] <= RST_VAL;
        else         q_o[i] <= q_o[i-1];
    end
  end
endmodule

// File: rtl/spi_divider.sv
module spi_divider #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o,
  output logic lvl_o
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          lvl_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(HALF - 1));
  assign tick_o = run_i && wrap;
  assign lvl_o  = run_i && lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      lvl_q <= ~lvl_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         pha_i,
  input  logic         tick_i,
  input  logic         sdi_i,
  output logic         sdo_o,
  output logic         done_o,
  output logic [W-1:0] rx_o
);
  localparam int unsigned EW    = $clog2(2 * W);
  localparam int unsigned LAST  = 2 * W - 1;

  logic [EW-1:0] edge_q;
  logic [W-1:0]  sreg_q;
  logic          rxb_q;
  logic          out_q;
  logic          sample_edge, change_edge, shift_now;

  // edge index parity picks sampling vs changing edge
  assign sample_edge = tick_i && (edge_q[0] == pha_i);
  assign change_edge = tick_i && (edge_q[0] != pha_i);
  assign shift_now   = pha_i ? sample_edge : change_edge;
  assign rx_o        = {sreg_q[W-2:0], (pha_i ? sdi_i : rxb_q)};
  assign done_o      = tick_i && (edge_q == EW'(LAST));
  assign sdo_o       = pha_i ? out_q : sreg_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= '0;
      sreg_q <= '0;
      rxb_q  <= 1'b0;
      out_q  <= 1'b0;
    end else if (load_i) begin
      edge_q <= '0;
      sreg_q <= load_val_i;
      out_q  <= load_val_i[W-1];
    end else begin
      if (clr_i)       edge_q <= '0;
      else if (tick_i) edge_q <= edge_q + 1'b1;
      if (sample_edge && !pha_i) rxb_q <= sdi_i;
      if (shift_now)             sreg_q <= rx_o;
      if (change_edge && pha_i)  out_q <= sreg_q[W-1];
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int unsigned    AW    = 8,
  parameter logic [AW-1:0]  BASE  = AW'(8'h28),
  parameter int unsigned    DIV   = 8,
  parameter int unsigned    SYNC  = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_en_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [7:0]    bus_wdata_i,
  output logic [7:0]    bus_rdata_o,
  input  logic          ss_ni,
  input  logic          ss_dir_i,
  output logic          ss_o,
  input  logic          sck_i,
  output logic          sck_o,
  input  logic          mosi_i,
  output logic          mosi_o,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          irq_o,
  output logic          mode_fault_o
);
  localparam logic [AW-1:0] A_CTRL = BASE;
  localparam logic [AW-1:0] A_STAT = BASE + AW'(1);
  localparam logic [AW-1:0] A_DATA = BASE + AW'(2);

  ctrl_t            ctrl_q;
  logic             done_q, fault_q, busy_q;
  logic [REG_W-1:0] rx_q;

  logic hit_ctrl, hit_stat, hit_data;
  logic wr_ctrl, wr_stat, wr_data;
  assign hit_ctrl = bus_en_i && (bus_addr_i == A_CTRL);
  assign hit_stat = bus_en_i && (bus_addr_i == A_STAT);
  assign hit_data = bus_en_i && (bus_addr_i == A_DATA);
  assign wr_ctrl  = hit_ctrl && bus_we_i;
  assign wr_stat  = hit_stat && bus_we_i;
  assign wr_data  = hit_data && bus_we_i;

  // pin synchronisers, equal depth keeps select and clock aligned
  logic [SYNC-1:0] ss_s, sck_s;
  spi_sync #(.STAGES(SYNC), .RST_VAL(1'b1)) u_ss_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ss_ni), .q_o(ss_s));
  spi_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_sck_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sck_i), .q_o(sck_s));

  logic sel, slv_tick, fault_now, start;
  assign sel       = ctrl_q.en && !ctrl_q.mst && !ss_s[SYNC-1];
  assign slv_tick  = sel && (sck_s[SYNC-2] ^ sck_s[SYNC-1]);
  assign fault_now = ctrl_q.en && ctrl_q.mst && !ss_dir_i && !ss_s[SYNC-2];
  assign start     = wr_data && ctrl_q.en && ctrl_q.mst && !busy_q && !fault_now;

  logic div_tick, div_lvl;
  spi_divider #(.DIV(DIV)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy_q),
    .tick_o(div_tick), .lvl_o(div_lvl));

  logic             sh_tick, sh_clr, sh_load, sh_sdi, sh_sdo, sh_done;
  logic [REG_W-1:0] sh_rx;
  assign sh_tick = ctrl_q.mst ? div_tick : slv_tick;
  assign sh_clr  = ctrl_q.mst ? !busy_q : !sel;
  assign sh_load = ctrl_q.mst ? start : wr_data;
  assign sh_sdi  = ctrl_q.mst ? miso_i : mosi_i;

  spi_shifter #(.W(REG_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(sh_clr), .load_i(sh_load),
    .load_val_i(bus_wdata_i), .pha_i(ctrl_q.pha), .tick_i(sh_tick),
    .sdi_i(sh_sdi), .sdo_o(sh_sdo), .done_o(sh_done), .rx_o(sh_rx));

  logic xfer_done;
  assign xfer_done = sh_done && (ctrl_q.mst ? busy_q : sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      busy_q  <= 1'b0;
      rx_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.ien <= bus_wdata_i[CB_IEN];
        ctrl_q.en  <= bus_wdata_i[CB_EN];
        ctrl_q.mst <= bus_wdata_i[CB_MST];
        ctrl_q.pol <= bus_wdata_i[CB_POL];
        ctrl_q.pha <= bus_wdata_i[CB_PHA];
      end
      if (fault_now) begin
        ctrl_q.en  <= 1'b0;
        ctrl_q.mst <= 1'b0;
        fault_q    <= 1'b1;
      end else if (wr_stat && !bus_wdata_i[SB_FAULT]) begin
        fault_q <= 1'b0;
      end
      if (start)
        busy_q <= 1'b1;
      else if (xfer_done || fault_now || !ctrl_q.en || !ctrl_q.mst)
        busy_q <= 1'b0;
      if (xfer_done)
        done_q <= 1'b1;
      else if (wr_stat && !bus_wdata_i[SB_DONE])
        done_q <= 1'b0;
      if (xfer_done) rx_q <= sh_rx;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (hit_ctrl) begin
      bus_rdata_o[CB_IEN] = ctrl_q.ien;
      bus_rdata_o[CB_EN]  = ctrl_q.en;
      bus_rdata_o[CB_MST] = ctrl_q.mst;
      bus_rdata_o[CB_POL] = ctrl_q.pol;
      bus_rdata_o[CB_PHA] = ctrl_q.pha;
    end else if (hit_stat) begin
      bus_rdata_o[SB_DONE]  = done_q;
      bus_rdata_o[SB_FAULT] = fault_q;
    end else if (hit_data) begin
      bus_rdata_o = rx_q;
    end
  end

  assign sck_o        = ctrl_q.pol ^ div_lvl;
  assign ss_o         = !(ss_dir_i && ctrl_q.mst && busy_q);
  assign mosi_o       = ctrl_q.mst && sh_sdo;
  assign miso_o       = sel && sh_sdo;
  assign irq_o        = done_q && ctrl_q.ien;
  assign mode_fault_o = fault_q;
endmodule

// File: rtl/spi_port_checker.sv
module spi_port_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic sck_o,
  input logic ss_o,
  input logic irq_o,
  input logic mode_fault_o,
  input logic busy,
  input logic en,
  input logic mst,
  input logic pol,
  input logic done
);
  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (sck_o == pol)); // R6
  AST_SEL_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> ss_o); // R12
  AST_DISABLED_NO_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !busy); // R10
  AST_FAULT_DROPS_ROLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_fault_o) |-> (!en && !mst && !busy)); // R11
  AST_DONE_ENDS_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done) && mst) |-> !busy); // R3
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done); // R8
endmodule

bind spi_port spi_port_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sck_o(sck_o), .ss_o(ss_o),
  .irq_o(irq_o), .mode_fault_o(mode_fault_o), .busy(busy_q),
  .en(ctrl_q.en), .mst(ctrl_q.mst), .pol(ctrl_q.pol), .done(done_q));

// File: tb/spi_port_test.sv
`timescale 1ns/1ps
module spi_port_test;
  localparam logic [7:0] BASE = 8'h28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       en_u = 0, en_p = 0, we = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic       m_ss_n = 1'b1, m_ss_dir = 1'b1;
  wire  [7:0] rd_u, rd_p;
  wire        u_ss, u_sck, u_mosi, u_miso_o, u_irq, u_mf;
  wire        p_miso, p_ss, p_sck, p_mosi, p_irq, p_mf;

  spi_port uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(en_u), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rd_u),
    .ss_ni(m_ss_n), .ss_dir_i(m_ss_dir), .ss_o(u_ss),
    .sck_i(1'b0), .sck_o(u_sck), .mosi_i(1'b0), .mosi_o(u_mosi),
    .miso_i(p_miso), .miso_o(u_miso_o), .irq_o(u_irq), .mode_fault_o(u_mf));

  spi_port peer (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(en_p), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rd_p),
    .ss_ni(u_ss), .ss_dir_i(1'b0), .ss_o(p_ss),
    .sck_i(u_sck), .sck_o(p_sck), .mosi_i(u_mosi), .mosi_o(p_mosi),
    .miso_i(1'b0), .miso_o(p_miso), .irq_o(p_irq), .mode_fault_o(p_mf));

  int n_chk = 0, n_fail = 0, sck_edges = 0;
  logic tb_pha = 1'b0;
  logic [15:0] exp_q[$];

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit peer_sel, input int ofs, input logic [7:0] d);
    @(negedge clk);
    addr = BASE + 8'(ofs); wdata = d; we = 1'b1;
    en_u = !peer_sel; en_p = peer_sel;
    @(negedge clk);
    we = 1'b0; en_u = 1'b0; en_p = 1'b0;
  endtask

  task automatic rd(input bit peer_sel, input int ofs, output logic [7:0] d);
    addr = BASE + 8'(ofs); we = 1'b0;
    en_u = !peer_sel; en_p = peer_sel;
    #0.5;
    d = peer_sel ? rd_p : rd_u;
    en_u = 1'b0; en_p = 1'b0;
  endtask

  always @(u_sck) sck_edges++;

  // monitor: rebuild both serial bytes on the sampling edges (R4, R5)
  initial begin
    forever begin
      logic [7:0] m, s;
      logic [15:0] e;
      @(negedge u_ss);
      m = 0; s = 0;
      for (int k = 0; k < 16; k++) begin
        @(u_sck);
        if ((k % 2) == int'(tb_pha)) begin
          m = {m[6:0], u_mosi};
          s = {s[6:0], p_miso};
        end
      end
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected transfer", 0, 1);
      end else begin
        e = exp_q.pop_front();
        chk(m == e[15:8], "R5 mosi bits MSB first", m, e[15:8]);
        chk(s == e[7:0], "R5 miso bits MSB first", s, e[7:0]);
      end
    end
  end

  task automatic xfer(input logic pol, input logic pha, input logic [7:0] a, input logic [7:0] b);
    logic [7:0] v;
    logic [7:0] mode;
    mode = {4'b0, pol, pha, 2'b0};
    tb_pha = pha;
    wr(1, 0, 8'h40 | mode);
    wr(1, 2, b);
    wr(0, 0, 8'hD0 | mode);
    exp_q.push_back({a, b});
    wr(0, 2, a);
    repeat (63) @(negedge clk);
    chk(u_irq == 1'b0, "R3 irq early", u_irq, 0);
    @(negedge clk);
    chk(u_irq == 1'b1, "R3 R8 irq at 8*DIV", u_irq, 1);
    rd(0, 1, v); chk(v == 8'h80, "R3 status done", v, 8'h80);
    repeat (8) @(negedge clk);
    rd(0, 2, v); chk(v == b, "R4 master rx", v, b);
    rd(1, 2, v); chk(v == a, "R7 slave rx", v, a);
    rd(1, 1, v); chk(v == 8'h80, "R7 slave done", v, 8'h80);
    chk(u_sck == pol, "R6 idle level", u_sck, pol);
    chk(u_ss == 1'b1, "R12 select released", u_ss, 1);
    wr(0, 1, 8'h00);
    rd(0, 1, v); chk(v == 8'h00, "R9 status cleared", v, 0);
    chk(u_irq == 1'b0, "R8 irq cleared", u_irq, 0);
    wr(1, 1, 8'h00);
  endtask

  initial begin
    logic [7:0] v;
    int e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, 0, v); chk(v == 8'h00, "R1 ctrl reset", v, 0);
    rd(0, 1, v); chk(v == 8'h00, "R1 status reset", v, 0);
    rd(0, 2, v); chk(v == 8'h00, "R1 data reset", v, 0);
    chk({u_sck, u_ss, u_irq, u_mf, u_mosi, u_miso_o} == 6'b010000, "R1 pins reset",
        {u_sck, u_ss, u_irq, u_mf, u_mosi, u_miso_o}, 6'b010000);
    wr(0, 0, 8'hFF);
    rd(0, 0, v); chk(v == 8'hDC, "R2 ctrl bits", v, 8'hDC);
    wr(0, 0, 8'h00);

    xfer(1'b0, 1'b0, 8'h5A, 8'hCC);
    xfer(1'b0, 1'b1, 8'hA5, 8'h3C);
    xfer(1'b1, 1'b0, 8'h81, 8'h7E);
    xfer(1'b1, 1'b1, 8'h0F, 8'hF0);

    // R10: disabled master
    wr(0, 0, 8'h90);
    e0 = sck_edges;
    wr(0, 2, 8'h33);
    repeat (80) @(negedge clk);
    chk(sck_edges == e0, "R10 no clock edges", sck_edges - e0, 0);
    rd(0, 1, v); chk(v == 8'h00, "R10 no done flag", v, 0);
    chk(u_ss == 1'b1, "R10 R12 select idle", u_ss, 1);

    // R11: mode fault
    m_ss_dir = 1'b0;
    wr(0, 0, 8'hD0);
    wr(0, 2, 8'h11);
    repeat (5) @(negedge clk);
    m_ss_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(u_mf == 1'b1, "R11 fault output", u_mf, 1);
    rd(0, 0, v); chk(v == 8'h80, "R11 ctrl bits cleared", v, 8'h80);
    rd(0, 1, v); chk(v == 8'h10, "R11 status fault", v, 8'h10);
    chk(u_sck == 1'b0, "R11 clock idle", u_sck, 0);
    e0 = sck_edges;
    repeat (80) @(negedge clk);
    chk(sck_edges == e0, "R11 transfer aborted", sck_edges - e0, 0);
    m_ss_n = 1'b1;
    wr(0, 1, 8'hEF);
    chk(u_mf == 1'b0, "R9 fault cleared", u_mf, 0);
    chk(exp_q.size() == 0, "R5 all transfers seen", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule